// File: doc/BRIEF.md
# Fuse Array Read Controller

This block lets software read a one-time-programmable fuse array of 1024 bytes through a small 32-bit register window. Software first sets the timing in a configuration register. It then writes a control word that holds a start byte address, a burst length minus one and a read enable bit. The controller walks the array one byte at a time. For each byte it drives the byte address for a programmable number of setup cycles, then raises the array strobe for a programmable number of cycles. It samples the returned byte on the last strobe cycle.

Each captured byte is placed into a bank of eight 32-bit staging words, packed little-endian. When the last byte is in, the controller raises a read-done status bit and clears its read enable. If the interrupt enable is set, it also raises a level interrupt. The interrupt stays high until software acknowledges it through the status register. The control register holds program and write enable bits and the status register has a write-done position, but fuse programming itself is not implemented.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset, the control (offset 0x0), configuration (0x4), status (0x8) and data words (0xC + 4·n, n = 0..7) all read zero, and `irq` is low.
- R2: The configuration register holds interrupt enable at bit 31, read setup count at 23:20, read strobe count at 19:16, write setup count at 15:12 and write strobe count at 11:0. It reads back what was written, and unlisted bits read zero.
- R3: A control write with bit 0 set while idle starts a read and clears status bit 0 at the same edge. Status bit 0 reads 1 exactly N·(A+S+2) clock edges after that write, where N is the byte count, A is the read setup count and S is the read strobe count.
- R4: For each byte, the address is held for A+1 cycles with the strobe low, then for S+1 cycles with the strobe high. The address does not change while the strobe is high.
- R5: Burst byte k is read from array address (start + k) and placed in data word k/4 at bits 8·(k mod 4)+7 : 8·(k mod 4).
- R6: The byte count is the control length field (bits 20:16) plus one. Every staging byte at or beyond that count reads zero after the read.
- R7: Control bit 0 (read enable) reads back 1 while the read runs and clears itself when the read completes. The start address (bits 30:21), length (bits 20:16), program enable (bit 15) and write enable (bit 1) read back as written.
- R8: Array addresses are 10 bits wide, and start + k wraps modulo 1024.
- R9: A control write while a read is in progress is ignored. It starts no strobe and does not change the control readback or the burst data.
- R10: With interrupt enable set, `irq` rises on the same edge as read-done. It stays high until the status register is written with bit 0 set, and writing 0 there leaves it high. With interrupt enable clear, `irq` stays low.
- R11: Status bit 1 (write done) always reads 0, and a control write with read enable clear starts no array access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| fa_addr | output | 10 | Array byte address |
| fa_strobe | output | 1 | Array read strobe |
| fa_rdata | input | 8 | Byte returned by the array |
| irq | output | 1 | Read-complete interrupt |

## Verification
The hardest case to reach is a control write that arrives in the middle of a running burst, because it must change nothing. The bench sets the largest setup and strobe counts so that the burst is long. It then issues a second control write with a different address a few cycles after the start. The scoreboard holds exactly one expected strobe per burst byte, so any extra or relocated strobe is seen as an unexpected or misplaced pulse. Reads that start near byte 1023 drive the address wrap.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
    // register word indices (bus_addr[5:2])
    localparam int IDX_CTRL = 0;
    localparam int IDX_CFG  = 1;
    localparam int IDX_STAT = 2;
    localparam int IDX_DATA = 3;

    // control field positions
    localparam int C_ADDR_LSB = 21;
    localparam int C_LEN_LSB  = 16;
    localparam int C_PG_BIT   = 15;
    localparam int C_WR_BIT   = 1;
    localparam int C_RD_BIT   = 0;

    // configuration field positions
    localparam int G_IEN_BIT  = 31;
    localparam int G_RADJ_LSB = 20;
    localparam int G_RSTR_LSB = 16;
    localparam int G_WADJ_LSB = 12;
    localparam int G_WSTR_LSB = 0;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_SETUP  = 2'd1,
        SQ_STROBE = 2'd2
    } sq_state_e;
endpackage

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
    import fuse_rd_pkg::*;
#(
    parameter int AW = 10,
    parameter int LW = 5,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [LW-1:0] last_idx,
    input  logic [CW-1:0] adj,
    input  logic [CW-1:0] str,
    output logic [AW-1:0] fa_addr,
    output logic          fa_strobe,
    output logic          cap_en,
    output logic [LW-1:0] cap_idx,
    output logic          done,
    output logic          busy
);
    typedef struct packed {
        sq_state_e     st;
        logic [CW-1:0] cnt;
        logic [LW-1:0] idx;
        logic [AW-1:0] base;
        logic [LW-1:0] last;
        logic [CW-1:0] adj;
        logic [CW-1:0] str;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d      = q;
        cap_en = 1'b0;
        done   = 1'b0;
        case (q.st)
            SQ_IDLE: begin
                if (start) begin
                    d.st   = SQ_SETUP;
                    d.cnt  = adj;
                    d.idx  = '0;
                    d.base = start_addr;
                    d.last = last_idx;
                    d.adj  = adj;
                    d.str  = str;
                end
            end
            SQ_SETUP: begin
                if (q.cnt == '0) begin
                    d.st  = SQ_STROBE;
                    d.cnt = q.str;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            SQ_STROBE: begin
                if (q.cnt == '0) begin
                    cap_en = 1'b1;
                    if (q.idx == q.last) begin
                        d.st = SQ_IDLE;
                        done = 1'b1;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.st  = SQ_SETUP;
                        d.cnt = q.adj;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: SQ_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign fa_addr   = q.base + AW'(q.idx);
    assign fa_strobe = (q.st == SQ_STROBE);
    assign cap_idx   = q.idx;
    assign busy      = (q.st != SQ_IDLE);
endmodule

// File: rtl/fuse_rd_buf.sv
module fuse_rd_buf #(
    parameter int NW = 8,
    parameter int LW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 cap_en,
    input  logic [LW-1:0]        cap_idx,
    input  logic [7:0]           cap_byte,
    output logic [NW-1:0][31:0]  words
);
    typedef struct packed {
        logic [NW-1:0][31:0] w;
    } buf_t;

    buf_t q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d.w = '0;
        end
        if (cap_en) begin
            d.w[cap_idx[LW-1:2]][{cap_idx[1:0], 3'b000} +: 8] = cap_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign words = q.w;
endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
    import fuse_rd_pkg::*;
#(
    parameter int FA_AW  = 10,
    parameter int LEN_W  = 5,
    parameter int CNT_W  = 4,
    parameter int WSTR_W = 12,
    parameter int BUS_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [FA_AW-1:0]  fa_addr,
    output logic              fa_strobe,
    input  logic [7:0]        fa_rdata,
    output logic              irq
);
    localparam int NWORDS = (1 << LEN_W) / 4;

    typedef struct packed {
        logic [FA_AW-1:0]  c_addr;
        logic [LEN_W-1:0]  c_len;
        logic              c_pg;
        logic              c_wr;
        logic              c_rd;
        logic              g_ien;
        logic [CNT_W-1:0]  g_radj;
        logic [CNT_W-1:0]  g_rstr;
        logic [CNT_W-1:0]  g_wadj;
        logic [WSTR_W-1:0] g_wstr;
        logic              rd_done;
        logic              irq;
    } reg_t;

    reg_t q, d;

    logic                   busy_w, done_w, cap_en_w, start_w;
    logic [LEN_W-1:0]       cap_idx_w;
    logic [NWORDS-1:0][31:0] words_w;
    logic [BUS_AW-3:0]      widx;
    logic                   wr_ctrl, wr_cfg, wr_stat;
    logic                   rd_done_w, int_en_w;

    assign widx    = bus_addr[BUS_AW-1:2];
    assign wr_ctrl = bus_sel && bus_wr && (int'(widx) == IDX_CTRL);
    assign wr_cfg  = bus_sel && bus_wr && (int'(widx) == IDX_CFG);
    assign wr_stat = bus_sel && bus_wr && (int'(widx) == IDX_STAT);
    assign start_w = wr_ctrl && !busy_w && bus_wdata[C_RD_BIT];

    always_comb begin
        d = q;
        if (wr_ctrl && !busy_w) begin
            d.c_addr = bus_wdata[C_ADDR_LSB +: FA_AW];
            d.c_len  = bus_wdata[C_LEN_LSB +: LEN_W];
            d.c_pg   = bus_wdata[C_PG_BIT];
            d.c_wr   = bus_wdata[C_WR_BIT];
            d.c_rd   = bus_wdata[C_RD_BIT];
        end
        if (start_w) begin
            d.rd_done = 1'b0;
        end
        if (wr_cfg) begin
            d.g_ien  = bus_wdata[G_IEN_BIT];
            d.g_radj = bus_wdata[G_RADJ_LSB +: CNT_W];
            d.g_rstr = bus_wdata[G_RSTR_LSB +: CNT_W];
            d.g_wadj = bus_wdata[G_WADJ_LSB +: CNT_W];
            d.g_wstr = bus_wdata[G_WSTR_LSB +: WSTR_W];
        end
        if (wr_stat && bus_wdata[0]) begin
            d.irq = 1'b0;
        end
        if (done_w) begin
            d.rd_done = 1'b1;
            d.c_rd    = 1'b0;
            if (q.g_ien) begin
                d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    fuse_rd_seq #(.AW(FA_AW), .LW(LEN_W), .CW(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_w),
        .start_addr (bus_wdata[C_ADDR_LSB +: FA_AW]),
        .last_idx   (bus_wdata[C_LEN_LSB +: LEN_W]),
        .adj        (q.g_radj),
        .str        (q.g_rstr),
        .fa_addr    (fa_addr),
        .fa_strobe  (fa_strobe),
        .cap_en     (cap_en_w),
        .cap_idx    (cap_idx_w),
        .done       (done_w),
        .busy       (busy_w)
    );

    fuse_rd_buf #(.NW(NWORDS), .LW(LEN_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_w),
        .cap_en   (cap_en_w),
        .cap_idx  (cap_idx_w),
        .cap_byte (fa_rdata),
        .words    (words_w)
    );

    always_comb begin
        bus_rdata = '0;
        if (int'(widx) == IDX_CTRL) begin
            bus_rdata[C_ADDR_LSB +: FA_AW] = q.c_addr;
            bus_rdata[C_LEN_LSB +: LEN_W]  = q.c_len;
            bus_rdata[C_PG_BIT]            = q.c_pg;
            bus_rdata[C_WR_BIT]            = q.c_wr;
            bus_rdata[C_RD_BIT]            = q.c_rd;
        end else if (int'(widx) == IDX_CFG) begin
            bus_rdata[G_IEN_BIT]             = q.g_ien;
            bus_rdata[G_RADJ_LSB +: CNT_W]   = q.g_radj;
            bus_rdata[G_RSTR_LSB +: CNT_W]   = q.g_rstr;
            bus_rdata[G_WADJ_LSB +: CNT_W]   = q.g_wadj;
            bus_rdata[G_WSTR_LSB +: WSTR_W]  = q.g_wstr;
        end else if (int'(widx) == IDX_STAT) begin
            bus_rdata[0] = q.rd_done;
        end else begin
            for (int n = 0; n < NWORDS; n++) begin
                if (int'(widx) == IDX_DATA + n) begin
                    bus_rdata = words_w[n];
                end
            end
        end
    end

    assign irq       = q.irq;
    assign rd_done_w = q.rd_done;
    assign int_en_w  = q.g_ien;
endmodule

// File: rtl/fuse_rd_chk.sv
module fuse_rd_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fa_strobe,
    input logic [AW-1:0] fa_addr,
    input logic          irq,
    input logic          rd_done,
    input logic          busy,
    input logic          int_en
);
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fa_strobe |=> (!fa_strobe || $stable(fa_addr)));

    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_done) |-> !busy);

    p_busy_no_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rd_done);

    p_no_strobe_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !fa_strobe);

    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($rose(rd_done) && int_en));
endmodule

bind fuse_rd_ctrl fuse_rd_chk #(.AW(FA_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fa_strobe (fa_strobe),
    .fa_addr   (fa_addr),
    .irq       (irq),
    .rd_done   (rd_done_w),
    .busy      (busy_w),
    .int_en    (int_en_w)
);

// File: tb/sim_fuse_rd_ctrl.sv
`timescale 1ns/1ps
module sim_fuse_rd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [9:0]  fa_addr;
    logic        fa_strobe;
    logic [7:0]  fa_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic ien = 1'b0;

    int exp_addr_q[$];
    int exp_wid_q[$];

    always #4 clk = ~clk;

    function automatic logic [7:0] fbyte(input int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    assign fa_rdata = fa_strobe ? fbyte(int'(fa_addr)) : 8'h00;

    fuse_rd_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fa_addr(fa_addr), .fa_strobe(fa_strobe), .fa_rdata(fa_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // monitor: one expected strobe pulse per byte (scoreboard)
    int run = 0;
    int cur_addr = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (fa_strobe) begin
                if (run == 0) cur_addr = int'(fa_addr);
                else if (int'(fa_addr) != cur_addr) chk("R4 addr moved", 32'(fa_addr), 32'(cur_addr));
                run++;
            end else if (run > 0) begin
                if (exp_addr_q.size() == 0) begin
                    chk("R9 unexpected strobe", 32'(cur_addr), 32'hFFFF_FFFF);
                end else begin
                    int ea, ew;
                    ea = exp_addr_q.pop_front();
                    ew = exp_wid_q.pop_front();
                    chk("R8 strobe address", 32'(cur_addr), 32'(ea));
                    chk("R4 strobe width", 32'(run), 32'(ew));
                end
                run = 0;
            end
        end
    end

    task automatic bus_write(input int idx, input logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'(idx * 4); bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int idx, output logic [31:0] data);
        bus_addr = 6'(idx * 4);
        #1;
        data = bus_rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input int a, input int n, input bit rd);
        return (32'(a & 1023) << 21) | (32'((n - 1) & 31) << 16) | 32'(rd);
    endfunction

    task automatic check_words(input int a, input int n, input string req);
        logic [31:0] v, e;
        for (int w = 0; w < 8; w++) begin
            e = '0;
            for (int b = 0; b < 4; b++) begin
                int k;
                k = w * 4 + b;
                if (k < n) e[8*b +: 8] = fbyte((a + k) & 1023);
            end
            bus_read(3 + w, v);
            chk(req, v, e);
        end
    endtask

    task automatic do_read(input int a, input int n, input int adj, input int str);
        logic [31:0] v;
        int t;
        bus_write(1, {ien, 7'd0, 4'(adj), 4'(str), 16'd0});
        for (int k = 0; k < n; k++) begin
            exp_addr_q.push_back((a + k) & 1023);
            exp_wid_q.push_back(str + 1);
        end
        bus_write(0, ctrl_word(a, n, 1'b1));
        bus_read(2, v);
        chk("R3 done cleared at start", v, 32'd0);
        bus_read(0, v);
        chk("R7 rd enable set while busy", v, ctrl_word(a, n, 1'b1));
        t = n * (adj + str + 2);
        repeat (t - 1) @(negedge clk);
        bus_read(2, v);
        chk("R3 done not early", v, 32'd0);
        @(negedge clk);
        bus_read(2, v);
        chk("R3 R11 done on time", v, 32'd1);
        bus_read(0, v);
        chk("R7 rd enable self-clears", v, ctrl_word(a, n, 1'b0));
        check_words(a, n, "R5 R6 data words");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk("watchdog expired", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 11; i++) begin
            bus_read(i, v);
            chk("R1 reset value", v, 32'd0);
        end
        chk("R1 irq reset", 32'(irq), 32'd0);

        // R2 configuration readback
        bus_write(1, 32'hFFFF_FFFF);
        bus_read(1, v);
        chk("R2 cfg all ones", v, 32'h80FF_FFFF);
        bus_write(1, 32'h0053_A123);
        bus_read(1, v);
        chk("R2 cfg pattern", v, 32'h0053_A123);

        // full 32-byte burst, several timings
        do_read(0, 32, 1, 2);
        do_read(64, 32, 0, 0);
        // R6 short burst
        do_read(100, 5, 2, 1);
        do_read(513, 1, 3, 0);
        // R8 wrap past 1023
        do_read(1020, 8, 0, 1);

        // R9 control write while busy is ignored
        bus_write(1, {8'd0, 4'd15, 4'd15, 16'd0});
        exp_addr_q.push_back(200); exp_wid_q.push_back(16);
        exp_addr_q.push_back(201); exp_wid_q.push_back(16);
        bus_write(0, ctrl_word(200, 2, 1'b1));
        repeat (5) @(negedge clk);
        bus_write(0, ctrl_word(300, 4, 1'b1) | 32'h8002);
        bus_read(0, v);
        chk("R9 ctrl unchanged while busy", v, ctrl_word(200, 2, 1'b1));
        for (int i = 0; i < 200; i++) begin
            bus_read(2, v);
            if (v[0]) break;
            @(negedge clk);
        end
        chk("R9 burst completes", v, 32'd1);
        repeat (40) @(negedge clk);
        chk("R9 no extra strobe queued", 32'(exp_addr_q.size()), 32'd0);
        check_words(200, 2, "R9 data from first address");

        // R10 interrupt
        ien = 1'b1;
        do_read(10, 3, 0, 0);
        chk("R10 irq after done", 32'(irq), 32'd1);
        bus_write(2, 32'd0);
        chk("R10 irq held on zero write", 32'(irq), 32'd1);
        bus_write(2, 32'd1);
        chk("R10 irq cleared", 32'(irq), 32'd0);
        ien = 1'b0;
        do_read(11, 2, 0, 0);
        chk("R10 irq disabled", 32'(irq), 32'd0);

        // R11 program/write enables start nothing, write-done stays 0
        bus_write(0, ctrl_word(40, 4, 1'b0) | 32'h8002);
        repeat (20) @(negedge clk);
        bus_read(0, v);
        chk("R11 R7 ctrl readback", v, ctrl_word(40, 4, 1'b0) | 32'h8002);
        bus_read(2, v);
        chk("R11 write done zero", v, 32'd1);
        chk("R11 no strobe pending", 32'(exp_addr_q.size()), 32'd0);
        check_words(11, 2, "R11 data untouched");

        finish_run();
    end
endmodule